// File: doc/BRIEF.md
# Single-Accumulator Fetch-Execute Core

This block is a small stored-program processor built around one 16-bit accumulator. Each instruction is a single 16-bit word whose upper four bits select the operation and whose lower twelve bits name a word address or, for the transfer-to-device operations, a device number. Every memory access, whether an instruction fetch or a data access, goes through an address register (MAR) and a buffer register (MBR). Fetch and execute run as separate sequential steps. The core is not pipelined.

Memory is a plain synchronous single port with one cycle of read latency. The core drives address, read enable, write enable and write data, and reads data one cycle after it raises the read enable. Devices sit behind a valid/ready request channel and a valid/ready response channel. A request carries a device number, a direction bit and the outgoing word. It stays on the pins, unchanged, until the device takes it. After an accepted read request, the core holds its response-ready high and waits for as many cycles as the device needs. The core never raises response-ready while a request is outstanding on the request channel.

Opcode 0 stops the core. An opcode the core does not recognise also stops it and raises a sticky illegal flag. Only reset leaves the stopped state. The program counter starts at a parameter value whose default is 300.

Top module: `acc_core`

## Requirements
- R1: After reset the first memory read is an instruction fetch from the start address (parameter, default 300). It appears in the first cycle after reset is released, and halted, illegal_op and carry are all 0.
- R2: Instructions are fetched one word at a time from successive addresses. Unless a jump intervenes, the next fetch is from the previous fetch address plus one.
- R3: Opcode 1 (bits 15:12 = 4'h1) loads the accumulator with the memory word at the address held in bits 11:0.
- R4: Opcode 2 writes the accumulator to the memory word at bits 11:0. Read enable and write enable are never high in the same cycle.
- R5: Opcode 5 adds the memory word at bits 11:0 to the accumulator modulo 2^16. Carry takes the carry-out of the most recent add, and no other opcode changes carry.
- R6: Opcode 3 issues a device request with io_req_write=0 and io_dev = bits 11:0. It then waits for a response and loads the accumulator with io_rsp_data. io_rsp_ready is never high while io_req_valid is high.
- R7: Opcode 7 issues a device request with io_req_write=1, io_dev = bits 11:0 and io_wdata = accumulator. While io_req_valid is high and io_req_ready is low, the request and all of its fields stay unchanged.
- R8: Opcode 8 makes the next fetch come from address bits 11:0 instead of the following word.
- R9: Opcode 0 stops the core: halted rises, illegal_op stays 0, and from then on no memory read, memory write or device request is issued until reset.
- R10: Any opcode other than 0, 1, 2, 3, 5, 7 and 8 stops the core the same way as opcode 0, and also sets illegal_op to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory word address (MAR) |
| mem_re | output | 1 | Memory read enable; data returns next cycle |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data (MBR) |
| mem_rdata | input | 16 | Memory read data, one cycle after mem_re |
| io_req_valid | output | 1 | Device request valid |
| io_req_ready | input | 1 | Device accepts the request |
| io_req_write | output | 1 | 1 = write to device, 0 = read from device |
| io_dev | output | 12 | Device number |
| io_wdata | output | 16 | Word sent to the device |
| io_rsp_valid | input | 1 | Device read data valid |
| io_rsp_ready | output | 1 | Core waits for read data |
| io_rsp_data | input | 16 | Device read data |
| halted | output | 1 | Core has stopped |
| illegal_op | output | 1 | Stopped on an unrecognised opcode |
| carry | output | 1 | Carry-out of the latest add |

## Verification
The hardest situation to reach is a device request that sits unaccepted for several cycles while the core must hold every request field steady. The read-response wait after an accepted request is equally hard to reach. The bench's device model takes a per-run latency for both channels. Sweeping that latency from zero to two across the add-and-output program stretches both handshakes without changing the expected arithmetic. The carry boundary is reached by sweeping operand pairs around 16'h7FFF, 16'h8000 and 16'hFFFF.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OP_W = 4;

  typedef enum logic [2:0] {
    ST_FADDR  = 3'd0,
    ST_FDATA  = 3'd1,
    ST_DECODE = 3'd2,
    ST_EADDR  = 3'd3,
    ST_EDATA  = 3'd4,
    ST_EWB    = 3'd5,
    ST_HALT   = 3'd6
  } state_t;

  localparam logic [OP_W-1:0] OP_HALT  = 4'h0;
  localparam logic [OP_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OP_W-1:0] OP_STORE = 4'h2;
  localparam logic [OP_W-1:0] OP_IN    = 4'h3;
  localparam logic [OP_W-1:0] OP_ADD   = 4'h5;
  localparam logic [OP_W-1:0] OP_OUT   = 4'h7;
  localparam logic [OP_W-1:0] OP_JUMP  = 4'h8;

  function automatic logic op_known(input logic [OP_W-1:0] op);
    return (op == OP_HALT) || (op == OP_LOAD) || (op == OP_STORE) ||
           (op == OP_IN) || (op == OP_ADD) || (op == OP_OUT) || (op == OP_JUMP);
  endfunction
endpackage

// File: rtl/acc_add.sv
module acc_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] wide;
  always_comb begin
    wide = {1'b0, a} + {1'b0, b};
    sum  = wide[W-1:0];
    cout = wide[W];
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op,
  input  logic            io_req_ready,
  input  logic            io_rsp_valid,
  output state_t          state
);
  state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_FADDR:  nxt = ST_FDATA;
      ST_FDATA:  nxt = ST_DECODE;
      ST_DECODE: nxt = ST_EADDR;
      ST_EADDR: begin
        if (op == OP_HALT || !op_known(op)) nxt = ST_HALT;
        else if (op == OP_JUMP)             nxt = ST_FADDR;
        else                                nxt = ST_EDATA;
      end
      ST_EDATA: begin
        if (op == OP_LOAD || op == OP_ADD) nxt = ST_EWB;
        else if (op == OP_STORE)           nxt = ST_FADDR;
        else if (op == OP_IN)              nxt = io_req_ready ? ST_EWB : ST_EDATA;
        else                               nxt = io_req_ready ? ST_FADDR : ST_EDATA;
      end
      ST_EWB: begin
        if (op == OP_IN) nxt = io_rsp_valid ? ST_FADDR : ST_EWB;
        else             nxt = ST_FADDR;
      end
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FADDR;
    else        state <= nxt;
  end

  // the stopped state is left only through reset
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_HALT |=> state == ST_HALT);
endmodule

// File: rtl/acc_dp.sv
module acc_dp
  import acc_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          ADDR_W   = 12,
  parameter int unsigned START_PC = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  state_t            state,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              io_rsp_valid,
  input  logic [DATA_W-1:0] io_rsp_data,
  output logic [OP_W-1:0]   op,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic              carry,
  output logic              illegal
);
  localparam logic [ADDR_W-1:0] PC_RST = ADDR_W'(START_PC);

  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q, acc_q;
  logic [ADDR_W-1:0] field;
  logic [DATA_W-1:0] sum_w;
  logic              cout_w;

  assign op    = ir_q[DATA_W-1 -: OP_W];
  assign field = ir_q[ADDR_W-1:0];

  acc_add #(.W(DATA_W)) u_add (.a(acc_q), .b(mem_rdata), .sum(sum_w), .cout(cout_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= PC_RST;
      mar     <= '0;
      mbr     <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      carry   <= 1'b0;
      illegal <= 1'b0;
    end else begin
      unique case (state)
        ST_FADDR: mar <= pc_q;
        ST_DECODE: begin
          mbr  <= mem_rdata;
          ir_q <= mem_rdata;
          pc_q <= pc_q + ADDR_W'(1);
        end
        ST_EADDR: begin
          mar <= field;
          if (op == OP_JUMP) pc_q <= field;
          if (op == OP_STORE || op == OP_OUT) mbr <= acc_q;
          if (!op_known(op)) illegal <= 1'b1;
        end
        ST_EWB: begin
          if (op == OP_LOAD) begin
            mbr   <= mem_rdata;
            acc_q <= mem_rdata;
          end else if (op == OP_ADD) begin
            mbr   <= mem_rdata;
            acc_q <= sum_w;
            carry <= cout_w;
          end else if (op == OP_IN && io_rsp_valid) begin
            mbr   <= io_rsp_data;
            acc_q <= io_rsp_data;
          end
        end
        default: ;
      endcase
    end
  end

  // an instruction read is addressed with the current program counter
  p_fetch_from_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FDATA |-> mar == pc_q);

  // carry moves only on the write-back of an add
  p_carry_only_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(carry) |-> ($past(state) == ST_EWB && $past(op) == OP_ADD));
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          ADDR_W   = 12,
  parameter int unsigned START_PC = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              io_req_valid,
  input  logic              io_req_ready,
  output logic              io_req_write,
  output logic [ADDR_W-1:0] io_dev,
  output logic [DATA_W-1:0] io_wdata,
  input  logic              io_rsp_valid,
  output logic              io_rsp_ready,
  input  logic [DATA_W-1:0] io_rsp_data,
  output logic              halted,
  output logic              illegal_op,
  output logic              carry
);
  state_t            state;
  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mbr;

  acc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .op(op),
    .io_req_ready(io_req_ready), .io_rsp_valid(io_rsp_valid), .state(state)
  );

  acc_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .START_PC(START_PC)) u_dp (
    .clk(clk), .rst_n(rst_n), .state(state), .mem_rdata(mem_rdata),
    .io_rsp_valid(io_rsp_valid), .io_rsp_data(io_rsp_data),
    .op(op), .mar(mar), .mbr(mbr), .carry(carry), .illegal(illegal_op)
  );

  always_comb begin
    mem_addr     = mar;
    mem_wdata    = mbr;
    io_dev       = mar;
    io_wdata     = mbr;
    mem_re       = (state == ST_FDATA) ||
                   (state == ST_EDATA && (op == OP_LOAD || op == OP_ADD));
    mem_we       = (state == ST_EDATA) && (op == OP_STORE);
    io_req_valid = (state == ST_EDATA) && (op == OP_IN || op == OP_OUT);
    io_req_write = (op == OP_OUT);
    io_rsp_ready = (state == ST_EWB) && (op == OP_IN);
    halted       = (state == ST_HALT);
  end

  p_rw_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  p_rsp_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    io_rsp_ready |-> !io_req_valid);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    io_req_valid && !io_req_ready |=>
      io_req_valid && $stable(io_dev) && $stable(io_wdata) && $stable(io_req_write));

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_re && !mem_we && !io_req_valid);

  p_illegal_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> halted);
endmodule

// File: tb/acc_core_test.sv
module acc_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_re, mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        io_req_valid, io_req_write, io_rsp_ready;
  logic        io_req_ready = 1'b0;
  logic [11:0] io_dev;
  logic [15:0] io_wdata;
  logic        io_rsp_valid = 1'b0;
  logic [15:0] io_rsp_data = '0;
  logic        halted, illegal_op, carry;

  int n_cmp = 0;
  int n_bad = 0;
  int tcyc  = 0;

  logic [15:0] mem [4096];
  int          io_lat = 0;
  int          wcnt = 0, rcnt = 0;
  logic        rsp_pend = 1'b0;
  logic [11:0] rsp_dev = '0;
  logic [15:0] in_base = '0;
  logic [11:0] out_dev = '0;
  logic [15:0] out_data = '0;
  int          out_cnt = 0, we_cnt = 0, quiet_bad = 0;

  always #4 clk = ~clk;

  acc_core uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .io_req_valid(io_req_valid),
    .io_req_ready(io_req_ready), .io_req_write(io_req_write), .io_dev(io_dev),
    .io_wdata(io_wdata), .io_rsp_valid(io_rsp_valid), .io_rsp_ready(io_rsp_ready),
    .io_rsp_data(io_rsp_data), .halted(halted), .illegal_op(illegal_op), .carry(carry)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    tcyc <= tcyc + 1;
    if (tcyc > 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not end act=%0d exp<=190000", tcyc);
      summary();
      $finish;
    end
  end

  // synchronous memory, one cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  // device model and traffic monitor
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_req_ready <= 1'b0; io_rsp_valid <= 1'b0; rsp_pend <= 1'b0;
      wcnt <= 0; rcnt <= 0; out_cnt <= 0; we_cnt <= 0; quiet_bad <= 0;
    end else begin
      io_req_ready <= 1'b0;
      if (io_req_valid && !io_req_ready) begin
        if (wcnt >= io_lat) begin io_req_ready <= 1'b1; wcnt <= 0; end
        else wcnt <= wcnt + 1;
      end
      if (io_req_valid && io_req_ready) begin
        if (io_req_write) begin
          out_dev <= io_dev; out_data <= io_wdata; out_cnt <= out_cnt + 1;
        end else begin
          rsp_pend <= 1'b1; rsp_dev <= io_dev; rcnt <= 0;
        end
      end
      if (rsp_pend && !io_rsp_valid) begin
        if (rcnt >= io_lat) begin
          io_rsp_valid <= 1'b1; io_rsp_data <= in_base ^ {4'h0, rsp_dev};
        end else rcnt <= rcnt + 1;
      end
      if (io_rsp_valid && io_rsp_ready) begin
        io_rsp_valid <= 1'b0; rsp_pend <= 1'b0;
      end
      if (mem_we) we_cnt <= we_cnt + 1;
      if (halted && (mem_re || mem_we || io_req_valid)) quiet_bad <= quiet_bad + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic run(input int lat);
    int cyc;
    io_lat = lat;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 3000) begin
      n_cmp++; n_bad++;
      $display("FAIL run: core never halted act=%0d exp<3000", cyc);
    end
  endtask

  initial begin
    logic [15:0] vals [6];
    logic [16:0] s;
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF;
    vals[3] = 16'h8000; vals[4] = 16'hFFFF; vals[5] = 16'h1234;

    // R1: reset state and first fetch address
    clear_mem();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 halted in reset", {31'b0, halted}, 0);
    chk("R1 illegal in reset", {31'b0, illegal_op}, 0);
    chk("R1 carry in reset", {31'b0, carry}, 0);
    chk("R1 no traffic in reset", {29'b0, mem_re, mem_we, io_req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first read enable", {31'b0, mem_re}, 1);
    chk("R1 first fetch address", {20'b0, mem_addr}, 300);

    // R2 R3 R4 R5 R7 R9: add program swept over operand pairs and device latency
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        clear_mem();
        mem[300] = 16'h1940; mem[301] = 16'h5941; mem[302] = 16'h2941;
        mem[303] = 16'h7006; mem[304] = 16'h0000;
        mem[12'h940] = vals[i]; mem[12'h941] = vals[j];
        s = {1'b0, vals[i]} + {1'b0, vals[j]};
        run((i + j) % 3);
        chk("R3 R5 R4 stored sum", {16'b0, mem[12'h941]}, {16'b0, s[15:0]});
        chk("R5 carry of add", {31'b0, carry}, {31'b0, s[16]});
        chk("R7 device write data", {16'b0, out_data}, {16'b0, s[15:0]});
        chk("R7 device number", {20'b0, out_dev}, 32'h006);
        chk("R2 R9 clean halt", {30'b0, halted, illegal_op}, 32'h2);
      end
    end

    // R6: read from device, add memory, write to device
    for (int k = 0; k < 3; k++) begin
      clear_mem();
      in_base = 16'hA5A0 + 16'(k * 16'h0111);
      mem[300] = 16'h3005; mem[301] = 16'h5940; mem[302] = 16'h7006; mem[303] = 16'h0000;
      mem[12'h940] = 16'h0002;
      run(k);
      s = {1'b0, in_base ^ 16'h0005} + 17'h2;
      chk("R6 device read into accumulator", {16'b0, out_data}, {16'b0, s[15:0]});
      chk("R6 single device write", out_cnt, 1);
    end

    // R8: jump away, skipping an illegal word
    clear_mem();
    mem[300] = 16'h81F4; mem[301] = 16'hF000;
    mem[12'h1F4] = 16'h1940; mem[12'h1F5] = 16'h2950; mem[12'h1F6] = 16'h0000;
    mem[12'h940] = 16'hBEEF;
    run(0);
    chk("R8 jump target executed", {16'b0, mem[12'h950]}, 32'h0000BEEF);
    chk("R8 skipped word not run", {31'b0, illegal_op}, 0);

    // R5: load does not disturb carry set by an earlier add
    clear_mem();
    mem[300] = 16'h1940; mem[301] = 16'h5941; mem[302] = 16'h1942; mem[303] = 16'h0000;
    mem[12'h940] = 16'hFFFF; mem[12'h941] = 16'h0001; mem[12'h942] = 16'h0042;
    run(0);
    chk("R5 carry kept across load", {31'b0, carry}, 1);

    // R9: opcode 0 stops, no traffic afterwards
    clear_mem();
    mem[300] = 16'h0123; mem[301] = 16'h2941;
    run(1);
    repeat (20) @(negedge clk);
    chk("R9 halted stays", {31'b0, halted}, 1);
    chk("R9 illegal clear", {31'b0, illegal_op}, 0);
    chk("R9 no traffic when halted", quiet_bad, 0);
    chk("R9 no memory writes", we_cnt, 0);

    // R10: every unrecognised opcode stops with the flag
    for (int op = 0; op < 16; op++) begin
      if (op == 0 || op == 1 || op == 2 || op == 3 || op == 5 || op == 7 || op == 8) continue;
      clear_mem();
      mem[300] = {4'(op), 12'h941}; mem[301] = 16'h2941;
      run(0);
      repeat (5) @(negedge clk);
      chk($sformatf("R10 op %0h halted+illegal", op), {30'b0, halted, illegal_op}, 32'h3);
      chk($sformatf("R10 op %0h no side effects", op), we_cnt + out_cnt + quiet_bad, 0);
    end

    summary();
    $finish;
  end
endmodule